// File: doc/BRIEF.md
# Multi-Mode Countdown Timer with Watchdog

This block holds one programmable down-counter and one free-running up-counter behind a small register port. Software stores a reload value, picks one of three behaviours (auto-reloading periodic, single-shot timeout, or watchdog) and sets an enable bit. The down-counter steps on a tick from a power-of-two prescaler and pulses its interrupt when it reaches zero. A zero reload value keeps it silent.

In watchdog mode the counter has to be refreshed before it runs out. Writing the reload value refreshes it, and clearing the enable bit stops it. If it runs out, the block raises a system reset request and sets a sticky expiry flag. The surrounding chip answers the request by pulsing `rst_n`. That pulse clears every register in the block except the flag, which only `por_n` or a write of one clears, so boot firmware can see why the chip restarted.

The free-running counter advances once every 2^FREE_SHIFT clocks. Its compare interrupt rises when the counter steps onto the compare value. The interrupt stays high until software writes the compare register again.

Top module: `tmr_wdog_top`

## Requirements
- R1: While `rst_n` is low, every readable register (control, reload, count, compare, free count) reads 0 and `irq_timer`, `irq_cmp`, `sys_rst_req` are low. After `por_n` the status flag (address 3, bit 0) reads 0.
- R2: Periodic mode (control bits [2:1] = 0, enable = bit 0) with reload L > 0 and shift S (control bits [8:4]) produces one-cycle `irq_timer` pulses exactly L·2^S clocks apart, indefinitely.
- R3: One-shot mode (bits [2:1] = 1) produces a single `irq_timer` pulse. At that pulse the enable bit clears and the count (address 2) reads 0.
- R4: With reload value 0 and enable set, no `irq_timer` pulse occurs and the count stays 0.
- R5: Watchdog mode (bits [2:1] = 2) with reload L and shift S raises `sys_rst_req` L·2^S (±1 for prescaler phase) clocks after the last reload. The request stays high until `rst_n`.
- R6: In watchdog mode, writing the reload register (address 1) reloads the count, so refreshing it more often than the expiry time keeps `sys_rst_req` low.
- R7: Clearing the enable bit in watchdog mode before expiry prevents `sys_rst_req`.
- R8: Watchdog expiry sets the status flag (address 3, bit 0). The flag survives an `rst_n` pulse and is cleared by writing 1 to it or by `por_n`.
- R9: The free count (address 5) advances by exactly one every 2^FREE_SHIFT clocks.
- R10: `irq_cmp` rises on the clock where the free count becomes equal to the compare register (address 4). It stays high until the compare register is written, and that write clears it on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous block reset; does not touch the expiry flag |
| por_n | input | 1 | Active-low power-on reset for the expiry flag |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0 control, 1 reload, 3 status, 4 compare) |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 3 | Read address (0 control, 1 reload, 2 count, 3 status, 4 compare, 5 free count) |
| rd_data | output | DATA_W | Combinational read data |
| irq_timer | output | 1 | One-cycle pulse when the down-counter reaches zero |
| irq_cmp | output | 1 | Compare-match interrupt level |
| sys_rst_req | output | 1 | Watchdog system reset request |

## Verification
The hardest condition to reach is a watchdog expiry followed by a block reset while the flag must keep its value. The bench refreshes the counter on a fixed cadence shorter than the expiry window to show that no request appears. It then stops refreshing and times the request against the last reload. Only after that does it pulse `rst_n` alone, leaving `por_n` high, and read the flag back through the register port.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [1:0] {
        MODE_PERIODIC = 2'd0,
        MODE_ONESHOT  = 2'd1,
        MODE_WATCHDOG = 2'd2,
        MODE_RSVD     = 2'd3
    } tmr_mode_e;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_RELOAD = 3'd1;
    localparam logic [ADDR_W-1:0] A_COUNT  = 3'd2;
    localparam logic [ADDR_W-1:0] A_STATUS = 3'd3;
    localparam logic [ADDR_W-1:0] A_CMP    = 3'd4;
    localparam logic [ADDR_W-1:0] A_FREE   = 3'd5;

    localparam int CTRL_SHIFT_LSB = 4;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PS_W    = 16,
    parameter int SHIFT_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SHIFT_W-1:0] shift,
    output logic               tick
);
    logic [PS_W-1:0] cnt_d, cnt_q;
    logic [PS_W-1:0] mask;

    always_comb begin
        cnt_d = cnt_q + 1'b1;
        mask  = '0;
        for (int i = 0; i < PS_W; i++) begin
            if (i < int'(shift)) mask[i] = 1'b1;
        end
        tick = ((cnt_q & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/tmr_countdown.sv
module tmr_countdown
    import tmr_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 32,
    parameter int SHIFT_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               wr_ctrl,
    input  logic               wr_reload,
    input  logic [DATA_W-1:0]  wdata,
    output logic               en,
    output tmr_mode_e          mode,
    output logic [SHIFT_W-1:0] shift,
    output logic [CNT_W-1:0]   reload,
    output logic [CNT_W-1:0]   count,
    output logic               irq,
    output logic               rst_req
);
    typedef struct packed {
        logic               en;
        tmr_mode_e          mode;
        logic [SHIFT_W-1:0] shift;
        logic [CNT_W-1:0]   reload;
        logic [CNT_W-1:0]   count;
        logic               irq;
        logic               rst_req;
    } cd_state_t;

    cd_state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.irq = 1'b0;
        if (wr_ctrl) begin
            s_d.en    = wdata[0];
            s_d.mode  = tmr_mode_e'(wdata[2:1]);
            s_d.shift = wdata[CTRL_SHIFT_LSB +: SHIFT_W];
            if (wdata[0] && !s_q.en) s_d.count = s_q.reload;
        end else if (wr_reload) begin
            s_d.reload = wdata[CNT_W-1:0];
            s_d.count  = wdata[CNT_W-1:0];
        end else if (s_q.en && tick && (s_q.reload != '0)) begin
            if (s_q.count > CNT_W'(1)) begin
                s_d.count = s_q.count - 1'b1;
            end else begin
                s_d.irq = 1'b1;
                case (s_q.mode)
                    MODE_WATCHDOG: begin
                        s_d.en      = 1'b0;
                        s_d.count   = '0;
                        s_d.rst_req = 1'b1;
                    end
                    MODE_ONESHOT: begin
                        s_d.en    = 1'b0;
                        s_d.count = '0;
                    end
                    default: s_d.count = s_q.reload;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{en: 1'b0, mode: MODE_PERIODIC, shift: '0, reload: '0,
                             count: '0, irq: 1'b0, rst_req: 1'b0};
        else        s_q <= s_d;
    end

    assign en      = s_q.en;
    assign mode    = s_q.mode;
    assign shift   = s_q.shift;
    assign reload  = s_q.reload;
    assign count   = s_q.count;
    assign irq     = s_q.irq;
    assign rst_req = s_q.rst_req;

    AST_PERIODIC_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.irq && s_q.mode == MODE_PERIODIC) |-> (s_q.en && s_q.count == s_q.reload)); // R2
    AST_ONESHOT_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.irq && s_q.mode == MODE_ONESHOT) |-> (!s_q.en && s_q.count == '0)); // R3
    AST_ZERO_RELOAD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.reload == '0) |=> !s_q.irq); // R4
    AST_WDOG_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.rst_req |=> s_q.rst_req); // R5
endmodule

// File: rtl/tmr_freerun.sv
module tmr_freerun #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_cmp,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  free_cnt,
    output logic [CNT_W-1:0]  cmp,
    output logic              irq
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cmp;
        logic             irq;
    } fr_state_t;

    fr_state_t s_d, s_q;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        s_d     = s_q;
        cnt_inc = s_q.cnt + 1'b1;
        if (tick) s_d.cnt = cnt_inc;
        if (wr_cmp) begin
            s_d.cmp = wdata[CNT_W-1:0];
            s_d.irq = 1'b0;
        end else if (tick && (cnt_inc == s_q.cmp)) begin
            s_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign free_cnt = s_q.cnt;
    assign cmp      = s_q.cmp;
    assign irq      = s_q.irq;

    AST_CMP_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.irq && !wr_cmp) |=> s_q.irq); // R10
    AST_CMP_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmp |=> !s_q.irq); // R10
endmodule

// File: rtl/tmr_wdog_top.sv
module tmr_wdog_top
    import tmr_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int CNT_W      = 32,
    parameter int PS_W       = 16,
    parameter int FREE_SHIFT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [2:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_timer,
    output logic              irq_cmp,
    output logic              sys_rst_req
);
    localparam int SHIFT_W = $clog2(PS_W + 1);

    logic               cd_tick, fr_tick;
    logic               cd_en;
    tmr_mode_e          cd_mode;
    logic [SHIFT_W-1:0] cd_shift;
    logic [CNT_W-1:0]   cd_reload, cd_count, fr_cnt, fr_cmp;
    logic               flag_d, flag_q;
    logic               wr_ctrl, wr_reload, wr_status, wr_cmp;

    always_comb begin
        wr_ctrl   = wr_en && (wr_addr == A_CTRL);
        wr_reload = wr_en && (wr_addr == A_RELOAD);
        wr_status = wr_en && (wr_addr == A_STATUS);
        wr_cmp    = wr_en && (wr_addr == A_CMP);
    end

    tmr_prescaler #(.PS_W(PS_W), .SHIFT_W(SHIFT_W)) u_cd_ps (
        .clk(clk), .rst_n(rst_n), .shift(cd_shift), .tick(cd_tick)
    );

    tmr_prescaler #(.PS_W(PS_W), .SHIFT_W(SHIFT_W)) u_fr_ps (
        .clk(clk), .rst_n(rst_n), .shift(SHIFT_W'(FREE_SHIFT)), .tick(fr_tick)
    );

    tmr_countdown #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SHIFT_W(SHIFT_W)) u_cd (
        .clk(clk), .rst_n(rst_n), .tick(cd_tick),
        .wr_ctrl(wr_ctrl), .wr_reload(wr_reload), .wdata(wr_data),
        .en(cd_en), .mode(cd_mode), .shift(cd_shift),
        .reload(cd_reload), .count(cd_count),
        .irq(irq_timer), .rst_req(sys_rst_req)
    );

    tmr_freerun #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_fr (
        .clk(clk), .rst_n(rst_n), .tick(fr_tick),
        .wr_cmp(wr_cmp), .wdata(wr_data),
        .free_cnt(fr_cnt), .cmp(fr_cmp), .irq(irq_cmp)
    );

    // Sticky expiry flag: only power-on reset or write-one clears it.
    always_comb begin
        flag_d = flag_q;
        if (wr_status && wr_data[0]) flag_d = 1'b0;
        if (sys_rst_req)             flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL: begin
                rd_data[0]                          = cd_en;
                rd_data[2:1]                        = cd_mode;
                rd_data[CTRL_SHIFT_LSB +: SHIFT_W]  = cd_shift;
            end
            A_RELOAD: rd_data[CNT_W-1:0] = cd_reload;
            A_COUNT:  rd_data[CNT_W-1:0] = cd_count;
            A_STATUS: rd_data[0]         = flag_q;
            A_CMP:    rd_data[CNT_W-1:0] = fr_cmp;
            A_FREE:   rd_data[CNT_W-1:0] = fr_cnt;
            default:  rd_data = '0;
        endcase
    end

    AST_FLAG_ON_EXPIRY: assert property (@(posedge clk) disable iff (!por_n)
        sys_rst_req |=> flag_q); // R8
    AST_DISABLED_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!cd_en && !sys_rst_req) |=> !sys_rst_req); // R7
endmodule

// File: tb/tmr_wdog_top_bench.sv
module tmr_wdog_top_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq_timer, irq_cmp, sys_rst_req;

    int checks = 0;
    int errors = 0;
    longint cyc = 0;

    tmr_wdog_top u_tmr_wdog_top (
        .clk(clk), .rst_n(rst_n), .por_n(por_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_timer(irq_timer), .irq_cmp(irq_cmp), .sys_rst_req(sys_rst_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        @(negedge clk);
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            if (a != 3) check("R1", $sformatf("reg %0d in reset", a), v, 0);
        end
        check("R1", "outputs in reset", {irq_timer, irq_cmp, sys_rst_req}, 0);
        rd(3'd3, v);
        check("R1", "flag after por", v[0], 0);
    endtask

    task automatic t_periodic(input int lim, input int sh);
        longint t[3];
        int n = 0;
        wr(3'd1, lim);
        wr(3'd0, (sh << 4) | 1);
        for (int g = 0; g < 5000 && n < 3; g++) begin
            @(negedge clk);
            if (irq_timer) begin t[n] = cyc; n++; end
        end
        check("R2", "pulses seen", n, 3);
        if (n == 3) begin
            check("R2", $sformatf("interval 1 lim=%0d sh=%0d", lim, sh), t[1] - t[0], lim << sh);
            check("R2", $sformatf("interval 2 lim=%0d sh=%0d", lim, sh), t[2] - t[1], lim << sh);
        end
        wr(3'd0, 0);
    endtask

    task automatic t_oneshot();
        logic [31:0] v;
        int n = 0;
        wr(3'd1, 4);
        wr(3'd0, (1 << 4) | (1 << 1) | 1);
        for (int g = 0; g < 100; g++) begin
            @(negedge clk);
            if (irq_timer) n++;
        end
        check("R3", "one-shot pulse count", n, 1);
        rd(3'd0, v);
        check("R3", "enable cleared", v[0], 0);
        rd(3'd2, v);
        check("R3", "count at zero", v, 0);
    endtask

    task automatic t_zero_reload();
        logic [31:0] v;
        int n = 0;
        wr(3'd0, 0);
        wr(3'd1, 0);
        wr(3'd0, 1);
        for (int g = 0; g < 60; g++) begin
            @(negedge clk);
            if (irq_timer) n++;
        end
        check("R4", "pulses with zero reload", n, 0);
        rd(3'd2, v);
        check("R4", "count stays zero", v, 0);
        wr(3'd0, 0);
    endtask

    task automatic t_watchdog();
        logic [31:0] v;
        longint k, e;
        wr(3'd1, 6);
        wr(3'd0, (1 << 4) | (2 << 1) | 1);
        for (int i = 0; i < 10; i++) begin
            repeat (6) @(negedge clk);
            wr(3'd1, 6);
        end
        check("R6", "no request while refreshed", sys_rst_req, 0);
        k = cyc;
        e = -1;
        for (int g = 0; g < 40 && e < 0; g++) begin
            @(negedge clk);
            if (sys_rst_req) e = cyc;
        end
        check("R5", "request raised", sys_rst_req, 1);
        check("R5", "expiry delay in window", (e - k >= 11 && e - k <= 12), 1);
        repeat (5) @(negedge clk);
        check("R5", "request held", sys_rst_req, 1);
        rd(3'd3, v);
        check("R8", "flag set on expiry", v[0], 1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8", "request cleared by reset", sys_rst_req, 0);
        rd(3'd0, v);
        check("R8", "control cleared by reset", v, 0);
        rd(3'd3, v);
        check("R8", "flag survives reset", v[0], 1);
        wr(3'd3, 1);
        rd(3'd3, v);
        check("R8", "flag cleared by write one", v[0], 0);
    endtask

    task automatic t_wdog_disable();
        wr(3'd1, 8);
        wr(3'd0, (2 << 1) | 1);
        repeat (2) @(negedge clk);
        wr(3'd0, (2 << 1));
        repeat (30) @(negedge clk);
        check("R7", "no request after disable", sys_rst_req, 0);
    endtask

    task automatic t_free_rate();
        logic [31:0] a, b;
        @(negedge clk);
        rd(3'd5, a);
        repeat (40) @(negedge clk);
        rd(3'd5, b);
        check("R9", "free count advance over 40 clocks", b - a, 10);
    endtask

    task automatic t_compare();
        logic [31:0] f, v;
        bit seen = 0;
        @(negedge clk);
        rd(3'd5, f);
        wr(3'd4, f + 8);
        check("R10", "irq low after compare write", irq_cmp, 0);
        for (int g = 0; g < 100 && !seen; g++) begin
            @(negedge clk);
            if (irq_cmp) seen = 1;
        end
        check("R10", "irq raised", seen, 1);
        rd(3'd5, v);
        check("R10", "free equals compare at rise", v, f + 8);
        repeat (30) @(negedge clk);
        check("R10", "irq held", irq_cmp, 1);
        wr(3'd4, f + 1000);
        check("R10", "irq cleared by write", irq_cmp, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        por_n = 1'b1;
        rst_n = 1'b1;
        t_periodic(5, 2);
        t_periodic(3, 0);
        t_oneshot();
        t_zero_reload();
        t_watchdog();
        t_wdog_disable();
        t_free_rate();
        t_compare();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule